// File: doc/BRIEF.md
# Relocatable memory map decoder

This block is the address decoder of a small 8-bit controller with a 16-bit address space. On each bus access it decides which internal resource answers: a 64-byte control-register window, a 512-byte RAM window, an EEPROM window or a ROM window. An address that none of them claims goes to the external bus. One select line, or the external flag, is raised for each access. The memory arrays are outside this block.

The register window and the RAM window can be moved at run time to the start of any 4-Kbyte page. Their pages come from an 8-bit page register, which lives inside the register window. Software may load that register once, and only while a short window after reset is still open. The window is counted in E-clock ticks. After the write, or once the window closes, the register is frozen. A test mode removes the time limit but keeps the single-write rule.

The ROM and EEPROM windows sit at fixed addresses. Each is gated by a configuration enable bit. In single-chip operation the ROM is decoded whatever its enable bit says.

Top module: `memmap_decoder`

## Requirements
- R1: After reset, `map_rdata` reads 0x01. This puts RAM at page 0x0 (0x0000) and the register window at page 0x1 (0x1000).
- R2: During an access, an address whose top nibble equals `map_rdata[3:0]` and whose low 12 bits are below 0x040 raises `sel[0]` (register window).
- R3: During an access, an address whose top nibble equals `map_rdata[7:4]` and whose low 12 bits are below 0x200 raises `sel[1]` (RAM window), unless R2 claims it.
- R4: A write access to offset 0x03D of the register window is accepted in two cases: in normal mode, while fewer than 64 E-clock ticks (`e_tick` pulses) have been seen since reset; and at any time in test mode. An accepted write shows on `map_rdata` from the next clock edge.
- R5: Once one write has been accepted, every later write to the page register leaves `map_rdata` unchanged until reset.
- R6: With `test_mode` low, a write to the page register after 64 or more E-clock ticks leaves `map_rdata` unchanged. A write after exactly 63 ticks is still accepted.
- R7: With `test_mode` high, a first write is accepted after any number of ticks, and a second write is still ignored.
- R8: Addresses 0xB600 to 0xB7FF raise `sel[2]` (EEPROM) when `ee_en` is 1, unless R2 or R3 claims them. When `ee_en` is 0 they go to the external bus.
- R9: Addresses 0xD000 to 0xFFFF raise `sel[3]` (ROM) when `rom_en` or `single_chip` is 1, unless R2, R3 or R8 claims them. Otherwise they go to the external bus.
- R10: Where windows overlap, the winner is decided in this order: register window, RAM, EEPROM, ROM.
- R11: While `acc_en` is 1, exactly one of `sel[3:0]` and `ext_acc` is 1. While `acc_en` is 0, all of them are 0.
- R12: `map_rdata` always shows the current page register contents, whether the register is locked or not. It changes only on an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e_tick | input | 1 | One-cycle pulse per E-clock period |
| acc_en | input | 1 | A bus access is taking place this cycle |
| rnw | input | 1 | 1 for read, 0 for write |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| test_mode | input | 1 | Lifts the time limit on the page register write |
| single_chip | input | 1 | Single-chip operation; forces the ROM on |
| rom_en | input | 1 | ROM window enable |
| ee_en | input | 1 | EEPROM window enable |
| sel | output | 4 | One-hot selects: bit0 register, bit1 RAM, bit2 EEPROM, bit3 ROM |
| ext_acc | output | 1 | Access goes to the external bus |
| map_rdata | output | 8 | Page register contents: RAM page in [7:4], register page in [3:0] |

## Verification
The hardest cases to reach from the ports are the edges of the write window. One is a write landing on the 63rd tick versus the 64th tick after reset. The other is a write that arrives after the register has already been relocated, which must be aimed at the new register page. The stimulus handles the first by resetting the block repeatedly and issuing an exact number of `e_tick` pulses before the write. It handles the second by computing the page register address from the bench's own model of the register. Random reads and writes are also spread over the relocated pages and over the overlap zones, with the enable and mode bits drawn at random.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
    // select vector layout, lowest index wins an overlap
    localparam int SEL_W   = 4;
    localparam int SEL_REG = 0;
    localparam int SEL_RAM = 1;
    localparam int SEL_EE  = 2;
    localparam int SEL_ROM = 3;
endpackage

// File: rtl/memmap_window.sv
module memmap_window #(
    parameter int ADDR_W     = 16,
    parameter int SIZE_BYTES = 64
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(SIZE_BYTES);

    logic [ADDR_W:0] offset;

    always_comb begin
        offset = {1'b0, addr} - {1'b0, base};
        hit    = en && !offset[ADDR_W] && (offset < LIMIT);
    end
endmodule

// File: rtl/memmap_priority.sv
module memmap_priority #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         none
);
    always_comb begin
        gnt  = '0;
        none = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && none) begin
                gnt[i] = 1'b1;
                none   = 1'b0;
            end
        end
    end
endmodule

// File: rtl/memmap_init_reg.sv
module memmap_init_reg #(
    parameter int               MAP_W     = 8,
    parameter int               WIN_TICKS = 64,
    parameter logic [MAP_W-1:0] RESET_MAP = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             e_tick,
    input  logic             test_mode,
    input  logic             wr_hit,
    input  logic [MAP_W-1:0] wdata,
    output logic [MAP_W-1:0] map_q
);
    localparam int              CNT_W = $clog2(WIN_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WIN_TICKS);

    typedef struct packed {
        logic [MAP_W-1:0] map;
        logic [CNT_W-1:0] ecnt;
        logic             written;
    } init_state_t;

    init_state_t st_d, st_q;
    logic        win_open;

    always_comb begin
        st_d     = st_q;
        win_open = test_mode || (st_q.ecnt < LIMIT);
        // tick counter saturates at the window length
        if (e_tick && (st_q.ecnt < LIMIT)) begin
            st_d.ecnt = st_q.ecnt + 1'b1;
        end
        if (wr_hit && !st_q.written && win_open) begin
            st_d.map     = wdata;
            st_d.written = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{map: RESET_MAP, ecnt: '0, written: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign map_q = st_q.map;
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BITS   = 4,
    parameter int REG_BYTES   = 64,
    parameter int RAM_BYTES   = 512,
    parameter int INIT_OFFSET = 'h03D,
    parameter int EE_BASE     = 'hB600,
    parameter int EE_BYTES    = 512,
    parameter int ROM_BASE    = 'hD000,
    parameter int ROM_BYTES   = 12288,
    parameter int WIN_TICKS   = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   e_tick,
    input  logic                   acc_en,
    input  logic                   rnw,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [2*PAGE_BITS-1:0] wdata,
    input  logic                   test_mode,
    input  logic                   single_chip,
    input  logic                   rom_en,
    input  logic                   ee_en,
    output logic [SEL_W-1:0]       sel,
    output logic                   ext_acc,
    output logic [2*PAGE_BITS-1:0] map_rdata
);
    localparam int MAP_W      = 2 * PAGE_BITS;
    localparam int PAGE_SHIFT = ADDR_W - PAGE_BITS;
    localparam int WIN_SIZE [SEL_W] = '{REG_BYTES, RAM_BYTES, EE_BYTES, ROM_BYTES};

    logic [MAP_W-1:0]  map_q;
    logic [ADDR_W-1:0] win_base [SEL_W];
    logic [SEL_W-1:0]  win_en;
    logic [SEL_W-1:0]  win_hit;
    logic [SEL_W-1:0]  req;
    logic [SEL_W-1:0]  gnt;
    logic              none;
    logic              wr_hit;

    always_comb begin
        win_base[SEL_REG] = {map_q[PAGE_BITS-1:0], {PAGE_SHIFT{1'b0}}};
        win_base[SEL_RAM] = {map_q[MAP_W-1:PAGE_BITS], {PAGE_SHIFT{1'b0}}};
        win_base[SEL_EE]  = ADDR_W'(EE_BASE);
        win_base[SEL_ROM] = ADDR_W'(ROM_BASE);
        win_en[SEL_REG]   = 1'b1;
        win_en[SEL_RAM]   = 1'b1;
        win_en[SEL_EE]    = ee_en;
        win_en[SEL_ROM]   = rom_en || single_chip;
    end

    for (genvar g = 0; g < SEL_W; g++) begin : g_win
        memmap_window #(
            .ADDR_W    (ADDR_W),
            .SIZE_BYTES(WIN_SIZE[g])
        ) u_win (
            .en  (win_en[g]),
            .base(win_base[g]),
            .addr(addr),
            .hit (win_hit[g])
        );
    end

    assign req = win_hit & {SEL_W{acc_en}};

    memmap_priority #(.N(SEL_W)) u_prio (
        .req (req),
        .gnt (gnt),
        .none(none)
    );

    assign sel     = gnt;
    assign ext_acc = acc_en && none;

    assign wr_hit = acc_en && !rnw && gnt[SEL_REG]
                  && (addr[PAGE_SHIFT-1:0] == PAGE_SHIFT'(INIT_OFFSET));

    memmap_init_reg #(
        .MAP_W    (MAP_W),
        .WIN_TICKS(WIN_TICKS),
        .RESET_MAP(MAP_W'(1))
    ) u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .e_tick   (e_tick),
        .test_mode(test_mode),
        .wr_hit   (wr_hit),
        .wdata    (wdata),
        .map_q    (map_q)
    );

    assign map_rdata = map_q;
endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        e_tick,
    input logic        acc_en,
    input logic        rnw,
    input logic [15:0] addr,
    input logic [7:0]  wdata,
    input logic        test_mode,
    input logic [3:0]  sel,
    input logic        ext_acc,
    input logic [7:0]  map_rdata
);
    logic [6:0] t_cnt;
    logic       t_wr;
    logic       wr_try;
    logic       open_w;

    assign wr_try = acc_en && !rnw && (addr == {map_rdata[3:0], 12'h03D});
    assign open_w = test_mode || (t_cnt < 7'd64);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_cnt <= '0;
            t_wr  <= 1'b0;
        end else begin
            if (e_tick && t_cnt < 7'd64) t_cnt <= t_cnt + 7'd1;
            if (wr_try) t_wr <= 1'b1;
        end
    end

    // R11
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> ($countones({ext_acc, sel}) == 1));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> ({ext_acc, sel} == 5'b0));

    // R4
    accept_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_try && open_w && !t_wr) |=> (map_rdata == $past(wdata)));

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_try && (t_wr || !open_w)) |=> $stable(map_rdata));

    // R12
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !rnw) |=> $stable(map_rdata));

    // R2
    reg_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && addr[15:12] == map_rdata[3:0] && addr[11:6] == 6'd0) |-> sel[0]);
endmodule

bind memmap_decoder memmap_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .e_tick   (e_tick),
    .acc_en   (acc_en),
    .rnw      (rnw),
    .addr     (addr),
    .wdata    (wdata),
    .test_mode(test_mode),
    .sel      (sel),
    .ext_acc  (ext_acc),
    .map_rdata(map_rdata)
);

// File: tb/memmap_decoder_test.sv
module memmap_decoder_test;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        e_tick = 1'b0;
    logic        acc_en = 1'b0;
    logic        rnw = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        test_mode = 1'b0;
    logic        single_chip = 1'b0;
    logic        rom_en = 1'b0;
    logic        ee_en = 1'b0;
    logic [3:0]  sel;
    logic        ext_acc;
    logic [7:0]  map_rdata;

    int total = 0;
    int bad = 0;

    // bench model
    logic [7:0] m_map;
    int         m_ticks;
    logic       m_wr;

    always #(CLK_NS/2) clk = ~clk;

    memmap_decoder uut (
        .clk(clk), .rst_n(rst_n), .e_tick(e_tick), .acc_en(acc_en), .rnw(rnw),
        .addr(addr), .wdata(wdata), .test_mode(test_mode), .single_chip(single_chip),
        .rom_en(rom_en), .ee_en(ee_en), .sel(sel), .ext_acc(ext_acc), .map_rdata(map_rdata)
    );

    function automatic logic [4:0] exp_dec(logic [15:0] a, logic [7:0] m,
                                           logic re, logic ee, logic sc);
        if (a[15:12] == m[3:0] && a[11:6] == 6'd0) return 5'b00001;
        if (a[15:12] == m[7:4] && a[11:9] == 3'd0) return 5'b00010;
        if (ee && a >= 16'hB600 && a <= 16'hB7FF) return 5'b00100;
        if ((re || sc) && a >= 16'hD000) return 5'b01000;
        return 5'b10000;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic tm);
        @(negedge clk);
        rst_n = 1'b0; acc_en = 1'b0; rnw = 1'b1; e_tick = 1'b0; test_mode = tm;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_map = 8'h01; m_ticks = 0; m_wr = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); e_tick = 1'b1;
            @(negedge clk); e_tick = 1'b0;
            if (m_ticks < 64) m_ticks++;
        end
    endtask

    task automatic rd(string req, logic [15:0] a, logic re, logic ee, logic sc);
        @(negedge clk);
        acc_en = 1'b1; rnw = 1'b1; addr = a; rom_en = re; ee_en = ee; single_chip = sc;
        #1;
        check(req, {11'd0, ext_acc, sel}, {11'd0, exp_dec(a, m_map, re, ee, sc)});
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; rnw = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        acc_en = 1'b0; rnw = 1'b1;
        if (a == {m_map[3:0], 12'h03D} && !m_wr && (test_mode || m_ticks < 64)) begin
            m_map = d; m_wr = 1'b1;
        end else if (a == {m_map[3:0], 12'h03D}) begin
            m_wr = 1'b1;
        end
        #1;
    endtask

    task automatic rand_phase(int n);
        for (int i = 0; i < n; i++) begin
            logic [15:0] a;
            logic [31:0] r;
            r = $urandom;
            case (r[1:0])
                2'd0: a = {m_map[3:0], 6'd0, 6'(r[15:10])};
                2'd1: a = {m_map[7:4], 3'd0, 9'(r[24:16])};
                2'd2: a = 16'hB400 + 16'(r[25:16]);
                default: a = 16'($urandom);
            endcase
            if (r[31:29] == 3'd0) begin
                wr(a, 8'($urandom));
                check("R12", {8'd0, map_rdata}, {8'd0, m_map});
            end else begin
                rd("R10", a, r[26], r[27], r[28]);
            end
        end
        @(negedge clk); acc_en = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);
        #1;
        check("R1", {8'd0, map_rdata}, 16'h0001);
        check("R11", {11'd0, ext_acc, sel}, 16'h0000);
        rd("R1", 16'h0000, 1'b0, 1'b0, 1'b0);
        rd("R2", 16'h103F, 1'b0, 1'b0, 1'b0);
        rd("R2", 16'h1040, 1'b0, 1'b0, 1'b0);
        rd("R3", 16'h01FF, 1'b0, 1'b0, 1'b0);
        rd("R3", 16'h0200, 1'b0, 1'b0, 1'b0);
        rd("R8", 16'hB600, 1'b0, 1'b1, 1'b0);
        rd("R8", 16'hB7FF, 1'b0, 1'b0, 1'b0);
        rd("R9", 16'hD000, 1'b1, 1'b0, 1'b0);
        rd("R9", 16'hFFFF, 1'b0, 1'b0, 1'b1);
        rd("R9", 16'hE000, 1'b0, 1'b0, 1'b0);
        rd("R11", 16'hC000, 1'b1, 1'b1, 1'b1);
        check("R11", {15'd0, ext_acc}, 16'h0001);
        rand_phase(300);

        // relocate, then try again at the new page
        do_reset(1'b0);
        ticks(10);
        wr(16'h103D, 8'hD3);
        check("R4", {8'd0, map_rdata}, 16'h00D3);
        rd("R10", 16'h3000, 1'b1, 1'b1, 1'b1);
        rd("R10", 16'hD100, 1'b1, 1'b1, 1'b1);
        rd("R10", 16'hD200, 1'b1, 1'b1, 1'b1);
        rd("R10", 16'h1000, 1'b1, 1'b1, 1'b1);
        wr(16'h303D, 8'h45);
        check("R5", {8'd0, map_rdata}, 16'h00D3);
        rand_phase(300);

        // overlap of RAM and register page
        do_reset(1'b0);
        wr(16'h103D, 8'hBB);
        rd("R10", 16'hB03F, 1'b0, 1'b1, 1'b0);
        rd("R10", 16'hB040, 1'b0, 1'b1, 1'b0);
        rd("R10", 16'hB600, 1'b0, 1'b1, 1'b0);

        // window edges
        do_reset(1'b0);
        ticks(63);
        wr(16'h103D, 8'h52);
        check("R6", {8'd0, map_rdata}, 16'h0052);
        do_reset(1'b0);
        ticks(64);
        wr(16'h103D, 8'h52);
        check("R6", {8'd0, map_rdata}, 16'h0001);
        ticks(5);
        wr(16'h103D, 8'h77);
        check("R6", {8'd0, map_rdata}, 16'h0001);

        // test mode
        do_reset(1'b1);
        ticks(100);
        wr(16'h103D, 8'h24);
        check("R7", {8'd0, map_rdata}, 16'h0024);
        wr(16'h403D, 8'h35);
        check("R7", {8'd0, map_rdata}, 16'h0024);
        rand_phase(200);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule